// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a virtual address into a physical address after the translation buffer has missed. It takes a miss request and the value of the first-level table base register. It then reads descriptors from translation tables in main memory through a read port that has a valid/ready request and one read in flight at a time. The walk takes one of two paths. A first-level descriptor either maps a large section directly, which needs one table read. It can instead point to a second-level table, and a page descriptor read from that table finishes the walk, which needs two dependent reads.

When the walk ends, the block raises a one-cycle completion pulse. With the pulse it hands the translation buffer the physical address, the access-permission field taken from the final descriptor, and a fault flag. A refill strobe marks a result that may be inserted. A fault descriptor at either level ends the walk at once, with no refill. The block takes no new request until its completion pulse has been given.

Top module: `ttw_walker`

## Requirements
- R1: The first-level read address is the 18-bit base register value, followed by virtual address bits 31..20, followed by two zero bits. The table is therefore 16 KB aligned and holds 4096 word entries.
- R2: A first-level descriptor is decoded on its bits 1..0: 01 points to a second-level table, 10 maps a section, and 00 or 11 is a fault.
- R3: For a section, the walk makes exactly one table read. The physical address is first-level descriptor bits 31..20 followed by virtual address bits 19..0.
- R4: The second-level read address is first-level descriptor bits 31..10, followed by virtual address bits 19..12, followed by two zero bits.
- R5: A second-level descriptor with bits 1..0 equal to 00 is a fault, and any other value is a page. For a page, the physical address is page descriptor bits 31..12 followed by virtual address bits 11..0.
- R6: The permission output is bits 5..4 of the descriptor that ended the walk. It is zero on a fault.
- R7: A fault at either level ends the walk with the fault flag at 1, the refill strobe at 0 and a physical address of zero. No further table read follows the fault.
- R8: A read request keeps its valid and its address stable until ready is seen. Only one read is in flight at a time.
- R9: A request that arrives during a walk, including one in the completion cycle, is ignored. The result reflects only the request that started the walk.
- R10: After reset, completion, refill and read valid are all 0. Completion is a single-cycle pulse, and refill is 1 exactly in a completion cycle without fault.
- R11: Counting from the clock edge that accepts the request, completion is visible after 3 edges for a first-level result and after 5 edges for a second-level result. Each cycle in which a read is held back by ready low adds one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request; sampled only when idle |
| req_va | input | 32 | Virtual address that missed |
| ttb_base | input | 18 | First-level table base, upper address bits |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Byte address of the descriptor |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk ended on a fault descriptor |
| walk_refill | output | 1 | Result may be inserted into the translation buffer |
| walk_pa | output | 32 | Translated physical address |
| walk_perm | output | 2 | Access-permission field of the final descriptor |

## Verification
The bench's memory model accepts a read after a chosen number of held-back cycles and returns the descriptor one cycle after acceptance. The expected completion is therefore 3 edges after request acceptance for a section or a first-level fault, and 5 edges for a page or a second-level fault, plus the held-back cycles. The bench counts falling edges from the request until completion and compares that count with the expected one. All result ports are sampled at that same falling edge, and the falling edge that follows confirms that the pulse has dropped. Every read address is logged when it is accepted and compared with the address computed from the request and the first-level descriptor.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
   typedef enum logic [1:0] {
      DK_FAULT,
      DK_TABLE,
      DK_SECTION,
      DK_PAGE
   } desc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_DONE
   } walk_state_e;
endpackage

// File: rtl/ttw_addr_gen.sv
module ttw_addr_gen #(
   parameter int VA_W     = 32,
   parameter int PA_W     = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   localparam int BASE_W    = PA_W - L1_IDX_W - 2,
   localparam int L2_BASE_W = PA_W - L2_IDX_W - 2,
   localparam int SEC_OFS_W = VA_W - L1_IDX_W
) (
   input  logic [VA_W-1:0]      va,
   input  logic [BASE_W-1:0]    l1_base,
   input  logic [L2_BASE_W-1:0] l2_base,
   input  logic                 use_l2,
   output logic [PA_W-1:0]      addr
);
   logic [PA_W-1:0] l1_addr;
   logic [PA_W-1:0] l2_addr;

   assign l1_addr = {l1_base, va[VA_W-1 -: L1_IDX_W], 2'b00};
   assign l2_addr = {l2_base, va[SEC_OFS_W-1 -: L2_IDX_W], 2'b00};
   assign addr    = use_l2 ? l2_addr : l1_addr;

   logic unused_va;
   assign unused_va = ^va;
endmodule

// File: rtl/ttw_desc_decode.sv
module ttw_desc_decode import ttw_pkg::*; #(
   parameter bit RSV_IS_FAULT = 1'b1
) (
   input  logic [1:0]  code,
   input  logic        second_level,
   output desc_kind_e  kind
);
   desc_kind_e l1_kind;
   desc_kind_e rsv_kind;

   generate
      if (RSV_IS_FAULT) begin : g_rsv_fault
         assign rsv_kind = DK_FAULT;
      end else begin : g_rsv_section
         assign rsv_kind = DK_SECTION;
      end
   endgenerate

   always_comb begin
      unique case (code)
         2'b01:   l1_kind = DK_TABLE;
         2'b10:   l1_kind = DK_SECTION;
         2'b11:   l1_kind = rsv_kind;
         default: l1_kind = DK_FAULT;
      endcase
   end

   assign kind = second_level ? ((code == 2'b00) ? DK_FAULT : DK_PAGE) : l1_kind;
endmodule

// File: rtl/ttw_result.sv
module ttw_result #(
   parameter int VA_W     = 32,
   parameter int PA_W     = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter int PERM_LSB = 4,
   parameter int PERM_W   = 2,
   localparam int SEC_OFS_W = VA_W - L1_IDX_W,
   localparam int PG_OFS_W  = SEC_OFS_W - L2_IDX_W
) (
   input  logic [PA_W-1:0]   desc,
   input  logic [VA_W-1:0]   va,
   output logic [PA_W-1:0]   pa_section,
   output logic [PA_W-1:0]   pa_page,
   output logic [PERM_W-1:0] perm
);
   assign pa_section = {desc[PA_W-1:SEC_OFS_W], va[SEC_OFS_W-1:0]};
   assign pa_page    = {desc[PA_W-1:PG_OFS_W], va[PG_OFS_W-1:0]};
   assign perm       = desc[PERM_LSB +: PERM_W];

   logic unused_in;
   assign unused_in = ^{desc, va};
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker import ttw_pkg::*; #(
   parameter int VA_W     = 32,
   parameter int PA_W     = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter int PERM_LSB = 4,
   parameter int PERM_W   = 2,
   parameter bit RSV_IS_FAULT = 1'b1,
   localparam int BASE_W    = PA_W - L1_IDX_W - 2,
   localparam int L2_BASE_W = PA_W - L2_IDX_W - 2,
   localparam int SEC_OFS_W = VA_W - L1_IDX_W,
   localparam int PG_OFS_W  = SEC_OFS_W - L2_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [BASE_W-1:0] ttb_base,
   output logic              mem_rd_valid,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rd_ready,
   input  logic              mem_rsp_valid,
   input  logic [PA_W-1:0]   mem_rsp_data,
   output logic              walk_done,
   output logic              walk_fault,
   output logic              walk_refill,
   output logic [PA_W-1:0]   walk_pa,
   output logic [PERM_W-1:0] walk_perm
);
   initial begin : cfg_chk
      assert (BASE_W > 0 && SEC_OFS_W > 0 && PG_OFS_W > 0)
         else $error("ttw_walker: index widths exceed address width");
      assert (PA_W > SEC_OFS_W)
         else $error("ttw_walker: section offset leaves no frame bits");
      assert (PERM_LSB >= 2 && PERM_LSB + PERM_W <= PG_OFS_W)
         else $error("ttw_walker: permission field overlaps type or frame bits");
   end

   walk_state_e          state_q;
   logic [VA_W-1:0]      va_q;
   logic [BASE_W-1:0]    base_q;
   logic [L2_BASE_W-1:0] l2_base_q;
   logic [PA_W-1:0]      pa_q;
   logic [PERM_W-1:0]    perm_q;
   logic                 fault_q;

   desc_kind_e           kind;
   logic [PA_W-1:0]      pa_sec;
   logic [PA_W-1:0]      pa_pg;
   logic [PERM_W-1:0]    perm_d;
   logic                 in_l2;

   assign in_l2 = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);

   ttw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)
   ) u_addr (
      .va(va_q), .l1_base(base_q), .l2_base(l2_base_q),
      .use_l2(in_l2), .addr(mem_rd_addr)
   );

   ttw_desc_decode #(.RSV_IS_FAULT(RSV_IS_FAULT)) u_dec (
      .code(mem_rsp_data[1:0]), .second_level(state_q == ST_L2_WAIT), .kind(kind)
   );

   ttw_result #(
      .VA_W(VA_W), .PA_W(PA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W),
      .PERM_LSB(PERM_LSB), .PERM_W(PERM_W)
   ) u_res (
      .desc(mem_rsp_data), .va(va_q),
      .pa_section(pa_sec), .pa_page(pa_pg), .perm(perm_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         base_q    <= '0;
         l2_base_q <= '0;
         pa_q      <= '0;
         perm_q    <= '0;
         fault_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  base_q  <= ttb_base;
                  state_q <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: if (mem_rd_ready) state_q <= ST_L1_WAIT;
            ST_L2_REQ: if (mem_rd_ready) state_q <= ST_L2_WAIT;
            ST_L1_WAIT, ST_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (kind)
                     DK_TABLE: begin
                        l2_base_q <= mem_rsp_data[PA_W-1 -: L2_BASE_W];
                        state_q   <= ST_L2_REQ;
                     end
                     DK_SECTION: begin
                        pa_q    <= pa_sec;
                        perm_q  <= perm_d;
                        fault_q <= 1'b0;
                        state_q <= ST_DONE;
                     end
                     DK_PAGE: begin
                        pa_q    <= pa_pg;
                        perm_q  <= perm_d;
                        fault_q <= 1'b0;
                        state_q <= ST_DONE;
                     end
                     default: begin
                        pa_q    <= '0;
                        perm_q  <= '0;
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                     end
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign walk_done    = (state_q == ST_DONE);
   assign walk_fault   = fault_q;
   assign walk_refill  = walk_done && !fault_q;
   assign walk_pa      = pa_q;
   assign walk_perm    = perm_q;

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   // R8
   one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> !walk_done);

   // R7
   done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(walk_done) |-> $past(mem_rsp_valid));

   // R9
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> !mem_rd_valid);
endmodule

// File: tb/tb_ttw_walker.sv
module tb_ttw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [17:0] ttb_base = '0;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ready;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        walk_done, walk_fault, walk_refill;
   logic [31:0] walk_pa;
   logic [1:0]  walk_perm;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ttw_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .ttb_base(ttb_base), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_fault(walk_fault),
      .walk_refill(walk_refill), .walk_pa(walk_pa), .walk_perm(walk_perm)
   );

   // memory model
   logic [31:0] exp_l1 = '0, exp_l2 = '0, d1 = '0, d2 = '0;
   int          stall_n = 0;
   int          wcnt;
   int          n_reads;
   logic [31:0] addr_log [4];

   assign mem_rd_ready = (wcnt >= stall_n);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         wcnt          <= 0;
         n_reads       <= 0;
      end else begin
         mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
         if (mem_rd_valid && mem_rd_ready) begin
            mem_rsp_data <= (mem_rd_addr == exp_l1) ? d1 :
                            (mem_rd_addr == exp_l2) ? d2 : 32'hBAD0_0000;
            addr_log[n_reads % 4] <= mem_rd_addr;
            n_reads <= n_reads + 1;
            wcnt    <= 0;
         end else if (mem_rd_valid) begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_walk(input logic [31:0] va, input logic [17:0] base,
                           input logic [31:0] l1d, input logic [31:0] l2d,
                           input int stall, input bit noise);
      logic [31:0] e_pa;
      logic [1:0]  e_perm;
      bit          e_fault;
      int          e_reads, e_cyc, cyc, r0;
      exp_l1  = {base, va[31:20], 2'b00};
      exp_l2  = {l1d[31:10], va[19:12], 2'b00};
      d1      = l1d;
      d2      = l2d;
      stall_n = stall;
      if (l1d[1:0] == 2'b10) begin
         e_pa = {l1d[31:20], va[19:0]}; e_perm = l1d[5:4]; e_fault = 0;
         e_reads = 1; e_cyc = 3 + stall;
      end else if (l1d[1:0] == 2'b01) begin
         e_reads = 2; e_cyc = 5 + 2 * stall;
         if (l2d[1:0] == 2'b00) begin
            e_pa = '0; e_perm = '0; e_fault = 1;
         end else begin
            e_pa = {l2d[31:12], va[11:0]}; e_perm = l2d[5:4]; e_fault = 0;
         end
      end else begin
         e_pa = '0; e_perm = '0; e_fault = 1; e_reads = 1; e_cyc = 3 + stall;
      end
      r0 = n_reads;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; ttb_base = base;
      cyc = 0;
      while (1) begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) begin
            if (noise) begin
               req_va = ~va; ttb_base = ~base;   // R9 stray request during walk
            end else begin
               req_valid = 1'b0;
            end
         end
         if (walk_done || cyc > 40) break;
      end
      req_valid = 1'b0;
      chk(cyc == e_cyc, "R11 done latency", cyc, e_cyc);
      chk(walk_fault == e_fault, "R2 R7 fault flag", {31'b0, walk_fault}, {31'b0, e_fault});
      chk(walk_pa == e_pa, "R3 R5 R9 physical address", walk_pa, e_pa);
      chk(walk_perm == e_perm, "R6 permission", {30'b0, walk_perm}, {30'b0, e_perm});
      chk(walk_refill == !e_fault, "R10 refill", {31'b0, walk_refill}, {31'b0, !e_fault});
      chk(n_reads - r0 == e_reads, "R7 R8 read count", n_reads - r0, e_reads);
      chk(addr_log[r0 % 4] == exp_l1, "R1 first-level address", addr_log[r0 % 4], exp_l1);
      if (e_reads == 2)
         chk(addr_log[(r0 + 1) % 4] == exp_l2, "R4 second-level address",
             addr_log[(r0 + 1) % 4], exp_l2);
      @(negedge clk);
      chk(!walk_done && !mem_rd_valid, "R10 done pulse single cycle",
          {30'b0, walk_done, mem_rd_valid}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!walk_done && !walk_refill && !mem_rd_valid, "R10 reset state",
          {29'b0, walk_done, walk_refill, mem_rd_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!walk_done && !mem_rd_valid, "R10 idle after reset",
          {30'b0, walk_done, mem_rd_valid}, 32'h0);
      for (int t = 0; t < 4; t++)
         for (int l2t = 0; l2t < 2; l2t++)
            for (int v = 0; v < 6; v++)
               for (int s = 0; s < 3; s++) begin
                  logic [31:0] va, h1, h2, l1d, l2d;
                  logic [17:0] base;
                  logic [1:0]  l2code;
                  va = 32'h9E37_79B9 * (v * 7 + t * 3 + s + l2t * 11 + 1);
                  if (v == 0) va = 32'h0000_0000;
                  if (v == 5) va = 32'hFFFF_FFFF;
                  h1 = (va ^ 32'hC2B2_AE35) * 32'h85EB_CA6B;
                  h2 = (h1 + 32'h2718_2818) * 32'h27D4_EB2F;
                  base = (v == 4) ? 18'h3FFFF : h2[31:14];
                  l2code = (l2t == 0) ? 2'b00 : 2'((v % 3) + 1);
                  l1d = {h1[31:2], 2'(t)};
                  l2d = {h2[31:2], l2code};
                  run_walk(va, base, l1d, l2d, s, v[0]);
               end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule